// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides, in one combinational pass, what a single translated memory access may do once its page-table entry has been found. It takes the second word of that entry, the two protection keys of the segment being accessed, the current privilege level, two feature enables, the load/store class mask and the fetch class mask, and the kind of access requested. Three separate rules each produce a read/write/execute set:

- the no-execute and guarded flags of the page;
- the 3-bit page protection code read under the segment key;
- the per-class masks indexed by the page's class key.

The block ANDs the three sets into the permitted set. It then compares that set with the requested access and raises a grant flag.

When the access is denied, the block explains why. On an instruction fetch it gives a no-execute/guarded reason or a protection reason, with a fixed precedence between the two, and a separate class-key reason. On a load or store it gives a protection reason, a class-key reason and a store marker.

Upstream logic supplies the entry once the table search has finished. Downstream logic uses the grant flag and the reason bits to install a translation or to raise the storage interrupt.

Top module: `page_perm_eval`

## Requirements
- R1: When the no-execute flag (entry bit 2) or the guarded flag (entry bit 3) is set, execute is removed from the permitted set. That rule never removes read or write.
- R2: The protection key is `seg_key_user` when `user_mode` is 1 and `seg_key_sup` when it is 0.
- R3: The protection code is {entry bit 63, entry bits 1:0}. Under key 0, codes 0, 1 and 2 allow read, write and execute. Codes 3 and 6 allow read and execute. Codes 4, 5 and 7 allow nothing.
- R4: Under key 1, code 2 allows read, write and execute, and codes 1 and 3 allow read and execute. Codes 0, 4, 5, 6 and 7 allow nothing.
- R5: When `key_en` is 1, the class key k is taken from entry bits 12:8 and selects the 2-bit field at bit 2*(31-k) of `load_store_mask`. The upper bit of that field removes write and the lower bit removes read. When `key_en` is 0 the mask has no effect.
- R6: When `key_en` and `fetch_mask_en` are both 1, the low bit of the same field position in `fetch_mask` removes execute only. Otherwise `fetch_mask` has no effect.
- R7: `perm_rwx` is {execute, write, read} and is the AND of the three rule sets. `acc_kind` encodes 0 as load, 1 as store, 2 as fetch, and 3 is treated as load. `grant` is 1 exactly when the requested right is in `perm_rwx`.
- R8: On a denied fetch, `ifault_nxg` is set if the R1 rule removed execute. `ifault_prot` is set only if R1 did not remove execute and the protection code did. `ifault_key` is set if the fetch mask removed execute.
- R9: On a denied load or store:
  - `dfault_prot` is set if the protection code removed the requested right;
  - `dfault_key` is set if the class mask removed it;
  - `dfault_store` is set for a store.

  All six fault outputs are 0 when `grant` is 1. The data fault outputs are 0 on a fetch, and the fetch fault outputs are 0 on a load or store.
- R10: Key 0 selects mask bits 63:62 and key 31 selects bits 1:0. Fields of other keys never affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| entry_word | input | 64 | Second word of the page-table entry |
| user_mode | input | 1 | 1 when the access is made in problem (user) state |
| seg_key_user | input | 1 | Segment protection key used in user state |
| seg_key_sup | input | 1 | Segment protection key used in supervisor state |
| key_en | input | 1 | Enables class-key protection |
| fetch_mask_en | input | 1 | Enables the fetch class mask (newer MMU versions) |
| load_store_mask | input | 64 | Per-class load/store deny mask, 2 bits per key |
| fetch_mask | input | 64 | Per-class fetch deny mask, 2 bits per key |
| acc_kind | input | 2 | Requested access: 0 load, 1 store, 2 fetch, 3 load |
| perm_rwx | output | 3 | Permitted set {execute, write, read} |
| grant | output | 1 | Requested access is permitted |
| ifault_nxg | output | 1 | Fetch denied by no-execute or guarded |
| ifault_prot | output | 1 | Fetch denied by protection code |
| ifault_key | output | 1 | Fetch denied by fetch class mask |
| dfault_prot | output | 1 | Load/store denied by protection code |
| dfault_key | output | 1 | Load/store denied by class mask |
| dfault_store | output | 1 | Denied data access was a store |

## Verification
The bench uses the default parameters: a 5-bit class key, which gives 32 classes and 64-bit masks, and the fetch mask built in. With these values the extreme key slots 0 and 31 are reachable, along with the complement-based field selection at both ends of the masks. Filling every other key's field with ones in the bench shows that only the indexed field matters. With the fetch mask built in, the runtime enable for newer MMU versions can be exercised in both states and combined with the no-execute/guarded precedence.

// File: rtl/ppe_pkg.sv
package ppe_pkg;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  typedef logic [2:0] perm_t;

  localparam perm_t PERM_ALL  = 3'b111;
  localparam perm_t PERM_RX   = 3'b101;
  localparam perm_t PERM_NONE = 3'b000;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_SPARE = 2'd3
  } acc_kind_e;

  // Protection code table, indexed by the selected segment key.
  function automatic perm_t pp_lookup(input logic key, input logic [2:0] code);
    perm_t p;
    p = PERM_NONE;
    if (!key) begin
      case (code)
        3'd0, 3'd1, 3'd2: p = PERM_ALL;
        3'd3, 3'd6:       p = PERM_RX;
        default:          p = PERM_NONE;
      endcase
    end else begin
      case (code)
        3'd2:       p = PERM_ALL;
        3'd1, 3'd3: p = PERM_RX;
        default:    p = PERM_NONE;
      endcase
    end
    return p;
  endfunction

  // Right needed by an access kind; the spare code behaves as a load.
  function automatic perm_t need_of(input acc_kind_e k);
    perm_t n;
    case (k)
      ACC_STORE: n = 3'b010;
      ACC_FETCH: n = 3'b100;
      default:   n = 3'b001;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/ppe_nxg_mask.sv
module ppe_nxg_mask
  import ppe_pkg::*;
(
  input  logic  nx_flag,
  input  logic  guard_flag,
  output perm_t perm_o,
  output logic  exec_block_o
);
  always_comb begin
    exec_block_o = nx_flag | guard_flag;
    perm_o       = PERM_ALL;
    if (exec_block_o) perm_o[PERM_X] = 1'b0;
  end
endmodule

// File: rtl/ppe_pp_mask.sv
module ppe_pp_mask
  import ppe_pkg::*;
(
  input  logic [2:0] prot_code,
  input  logic       user_mode,
  input  logic       seg_key_user,
  input  logic       seg_key_sup,
  output logic       prot_key_o,
  output perm_t      perm_o
);
  always_comb begin
    prot_key_o = user_mode ? seg_key_user : seg_key_sup;
    perm_o     = pp_lookup(prot_key_o, prot_code);
  end
endmodule

// File: rtl/ppe_class_key_mask.sv
module ppe_class_key_mask
  import ppe_pkg::*;
#(
  parameter int KEY_W          = 5,
  parameter bit HAS_FETCH_MASK = 1'b1,
  localparam int NUM_KEYS      = 2 ** KEY_W,
  localparam int MASK_W        = 2 * NUM_KEYS,
  localparam int SLOT_W        = KEY_W + 1
)(
  input  logic [KEY_W-1:0]  class_key,
  input  logic              key_en,
  input  logic              fetch_mask_en,
  input  logic [MASK_W-1:0] load_store_mask,
  input  logic [MASK_W-1:0] fetch_mask,
  output perm_t             perm_o,
  output logic [1:0]        ls_field_o,
  output logic              fetch_deny_o
);
  // Field offset 2*(NUM_KEYS-1-k): for a power-of-two key count that is ~k shifted by one.
  logic [SLOT_W-1:0] slot;
  assign slot       = {~class_key, 1'b0};
  assign ls_field_o = load_store_mask[slot +: 2];

  generate
    if (HAS_FETCH_MASK) begin : g_fetch
      logic [1:0] f_field;
      logic       f_field_unused;
      assign f_field        = fetch_mask[slot +: 2];
      assign f_field_unused = f_field[1];
      assign fetch_deny_o   = key_en & fetch_mask_en & f_field[0];
    end else begin : g_nofetch
      logic fetch_unused;
      assign fetch_unused = ^{fetch_mask, fetch_mask_en};
      assign fetch_deny_o = 1'b0;
    end
  endgenerate

  always_comb begin
    perm_o = PERM_ALL;
    if (key_en) begin
      if (ls_field_o[1]) perm_o[PERM_W] = 1'b0;
      if (ls_field_o[0]) perm_o[PERM_R] = 1'b0;
    end
    if (fetch_deny_o) perm_o[PERM_X] = 1'b0;
  end
endmodule

// File: rtl/page_perm_eval.sv
module page_perm_eval
  import ppe_pkg::*;
#(
  parameter int ENTRY_W        = 64,
  parameter int KEY_W          = 5,
  parameter int KEY_LSB        = 8,
  parameter int NX_BIT         = 2,
  parameter int GD_BIT         = 3,
  parameter int PP0_BIT        = 63,
  parameter bit HAS_FETCH_MASK = 1'b1,
  localparam int MASK_W        = 2 * (2 ** KEY_W)
)(
  input  logic [ENTRY_W-1:0] entry_word,
  input  logic               user_mode,
  input  logic               seg_key_user,
  input  logic               seg_key_sup,
  input  logic               key_en,
  input  logic               fetch_mask_en,
  input  logic [MASK_W-1:0]  load_store_mask,
  input  logic [MASK_W-1:0]  fetch_mask,
  input  logic [1:0]         acc_kind,
  output logic [2:0]         perm_rwx,
  output logic               grant,
  output logic               ifault_nxg,
  output logic               ifault_prot,
  output logic               ifault_key,
  output logic               dfault_prot,
  output logic               dfault_key,
  output logic               dfault_store
);
  // Named internal events, visible to the bound checker.
  perm_t            nxg_perm, pp_perm, key_perm, need;
  logic             exec_block, prot_key, fetch_deny;
  logic [1:0]       ls_field;
  logic [2:0]       prot_code;
  logic [KEY_W-1:0] class_key;
  logic             is_fetch, denied;
  acc_kind_e        kind;
  logic             entry_unused;

  assign prot_code    = {entry_word[PP0_BIT], entry_word[1:0]};
  assign class_key    = entry_word[KEY_LSB +: KEY_W];
  assign entry_unused = ^entry_word;
  assign kind         = acc_kind_e'(acc_kind);

  ppe_nxg_mask u_nxg (
    .nx_flag      (entry_word[NX_BIT]),
    .guard_flag   (entry_word[GD_BIT]),
    .perm_o       (nxg_perm),
    .exec_block_o (exec_block)
  );

  ppe_pp_mask u_pp (
    .prot_code    (prot_code),
    .user_mode    (user_mode),
    .seg_key_user (seg_key_user),
    .seg_key_sup  (seg_key_sup),
    .prot_key_o   (prot_key),
    .perm_o       (pp_perm)
  );

  ppe_class_key_mask #(
    .KEY_W          (KEY_W),
    .HAS_FETCH_MASK (HAS_FETCH_MASK)
  ) u_key (
    .class_key       (class_key),
    .key_en          (key_en),
    .fetch_mask_en   (fetch_mask_en),
    .load_store_mask (load_store_mask),
    .fetch_mask      (fetch_mask),
    .perm_o          (key_perm),
    .ls_field_o      (ls_field),
    .fetch_deny_o    (fetch_deny)
  );

  always_comb begin
    need     = need_of(kind);
    perm_rwx = nxg_perm & pp_perm & key_perm;
    grant    = |(need & perm_rwx);
    denied   = ~grant;
    is_fetch = (kind == ACC_FETCH);

    // Fetch: no-execute/guarded wins over protection code; class key reported alongside.
    ifault_nxg  = denied & is_fetch & ~nxg_perm[PERM_X];
    ifault_prot = denied & is_fetch & nxg_perm[PERM_X] & ~pp_perm[PERM_X];
    ifault_key  = denied & is_fetch & ~key_perm[PERM_X];

    dfault_prot  = denied & ~is_fetch & |(need & ~pp_perm);
    dfault_key   = denied & ~is_fetch & |(need & ~key_perm);
    dfault_store = denied & (kind == ACC_STORE);
  end
endmodule

// File: rtl/ppe_checker.sv
module ppe_checker #(
  parameter int ENTRY_W  = 64,
  parameter int KEY_W    = 5,
  parameter int KEY_LSB  = 8,
  parameter int NX_BIT   = 2,
  parameter int GD_BIT   = 3,
  parameter int PP0_BIT  = 63,
  localparam int NUM_KEYS = 2 ** KEY_W,
  localparam int MASK_W   = 2 * NUM_KEYS
)(
  input logic [ENTRY_W-1:0] entry_word,
  input logic               user_mode,
  input logic               seg_key_user,
  input logic               seg_key_sup,
  input logic               key_en,
  input logic               fetch_mask_en,
  input logic [MASK_W-1:0]  load_store_mask,
  input logic [MASK_W-1:0]  fetch_mask,
  input logic [1:0]         acc_kind,
  input logic [2:0]         perm_rwx,
  input logic               grant,
  input logic               ifault_nxg,
  input logic               ifault_prot,
  input logic               ifault_key,
  input logic               dfault_prot,
  input logic               dfault_key,
  input logic               dfault_store,
  input logic [2:0]         nxg_perm,
  input logic [2:0]         pp_perm,
  input logic [2:0]         key_perm,
  input logic               prot_key
);
  int         idx;
  logic [2:0] code;
  logic       chk_unused;

  assign chk_unused = ^{entry_word, fetch_mask, load_store_mask};

  always_comb begin
    idx  = 2 * (NUM_KEYS - 1 - int'(entry_word[KEY_LSB +: KEY_W]));
    code = {entry_word[PP0_BIT], entry_word[1:0]};

    if (entry_word[NX_BIT] || entry_word[GD_BIT])
      assert_nx_guard_R1: assert (!perm_rwx[2]) else $error("exec kept with nx/guard");
    assert_nxg_keeps_rw_R1: assert (nxg_perm[1:0] == 2'b11) else $error("nxg touched rw");

    assert_key_select_R2: assert (prot_key == (user_mode ? seg_key_user : seg_key_sup))
      else $error("wrong segment key");

    if (code == 3'd4 || code == 3'd5 || code == 3'd7)
      assert_undef_code_R3: assert (pp_perm == 3'b000) else $error("undefined code grants");

    if (key_en && load_store_mask[idx + 1])
      assert_store_mask_R5: assert (!perm_rwx[1]) else $error("store mask ignored");
    if (!key_en)
      assert_key_off_R5: assert (key_perm == 3'b111) else $error("class key active while off");

    if (key_en && fetch_mask_en && fetch_mask[idx])
      assert_fetch_mask_R6: assert (!perm_rwx[2]) else $error("fetch mask ignored");

    if (!grant)
      assert_denial_reason_R7: assert (ifault_nxg || ifault_prot || ifault_key || dfault_prot || dfault_key)
        else $error("denied with no reason");

    assert_fetch_prec_R8: assert ($onehot0({ifault_nxg, ifault_prot})) else $error("both fetch reasons");

    if (grant)
      assert_grant_clean_R9: assert ({ifault_nxg, ifault_prot, ifault_key, dfault_prot, dfault_key, dfault_store} == 6'b0)
        else $error("fault bits on grant");
    if (dfault_store)
      assert_store_flag_R9: assert (acc_kind == 2'd1) else $error("store flag on non-store");
  end
endmodule

bind page_perm_eval ppe_checker #(
  .ENTRY_W (ENTRY_W),
  .KEY_W   (KEY_W),
  .KEY_LSB (KEY_LSB),
  .NX_BIT  (NX_BIT),
  .GD_BIT  (GD_BIT),
  .PP0_BIT (PP0_BIT)
) u_ppe_checker (
  .entry_word      (entry_word),
  .user_mode       (user_mode),
  .seg_key_user    (seg_key_user),
  .seg_key_sup     (seg_key_sup),
  .key_en          (key_en),
  .fetch_mask_en   (fetch_mask_en),
  .load_store_mask (load_store_mask),
  .fetch_mask      (fetch_mask),
  .acc_kind        (acc_kind),
  .perm_rwx        (perm_rwx),
  .grant           (grant),
  .ifault_nxg      (ifault_nxg),
  .ifault_prot     (ifault_prot),
  .ifault_key      (ifault_key),
  .dfault_prot     (dfault_prot),
  .dfault_key      (dfault_key),
  .dfault_store    (dfault_store),
  .nxg_perm        (nxg_perm),
  .pp_perm         (pp_perm),
  .key_perm        (key_perm),
  .prot_key        (prot_key)
);

// File: tb/tb_page_perm_eval.sv
`timescale 1ns/1ps
module tb_page_perm_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] entry_word, load_store_mask, fetch_mask;
  logic        user_mode, seg_key_user, seg_key_sup, key_en, fetch_mask_en;
  logic [1:0]  acc_kind;
  logic [2:0]  perm_rwx;
  logic        grant, ifault_nxg, ifault_prot, ifault_key, dfault_prot, dfault_key, dfault_store;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  page_perm_eval dut (
    .entry_word(entry_word), .user_mode(user_mode), .seg_key_user(seg_key_user),
    .seg_key_sup(seg_key_sup), .key_en(key_en), .fetch_mask_en(fetch_mask_en),
    .load_store_mask(load_store_mask), .fetch_mask(fetch_mask), .acc_kind(acc_kind),
    .perm_rwx(perm_rwx), .grant(grant), .ifault_nxg(ifault_nxg), .ifault_prot(ifault_prot),
    .ifault_key(ifault_key), .dfault_prot(dfault_prot), .dfault_key(dfault_key),
    .dfault_store(dfault_store)
  );

  typedef struct packed {
    logic [2:0] code;
    logic       nx, gd, usr, kp, ks, cken, fmen;
    logic [4:0] key;
    logic [1:0] amrf, iamrf, kind;
    logic [2:0] eperm;
    logic       egrant;
  } vec_t;

  localparam int NV = 18;
  // code nx gd usr kp ks cken fmen key amrf iamrf kind eperm egrant
  localparam vec_t TBL [NV] = '{
    '{0,0,0,0,0,0,0,0, 0,0,0,0,7,1},  // R3 key0 code0 load
    '{3,0,0,0,0,0,0,0, 0,0,0,1,5,0},  // R3 code3 no write
    '{3,0,0,1,1,0,0,0, 0,0,0,2,5,1},  // R4 user key1 code3 fetch
    '{0,0,0,1,1,0,0,0, 0,0,0,0,0,0},  // R4 key1 code0 none
    '{2,0,0,1,1,0,0,0, 0,0,0,1,7,1},  // R4 key1 code2 all
    '{6,1,0,0,0,0,0,0, 0,0,0,2,1,0},  // R1 nx strips exec
    '{6,0,0,0,0,1,0,0, 0,0,0,0,0,0},  // R4 key1 code6 none
    '{5,0,0,0,0,0,0,0, 0,0,0,0,0,0},  // R3 undefined code
    '{1,0,0,0,0,0,1,0, 3,2,0,1,5,0},  // R5 store bit
    '{1,0,0,0,0,0,1,0, 3,1,0,1,6,1},  // R5 load bit
    '{1,0,0,0,0,0,0,0, 3,3,0,1,7,1},  // R5 disabled
    '{0,0,0,0,0,0,1,1, 7,0,1,2,3,0},  // R6 fetch mask
    '{0,0,0,0,0,0,1,0, 7,0,1,2,7,1},  // R6 fetch mask off
    '{1,0,1,0,0,1,0,0, 0,0,0,0,1,1},  // R1 guarded keeps read
    '{3,0,0,0,0,0,0,0, 0,0,0,3,5,1},  // R7 spare kind as load
    '{7,0,0,1,1,0,0,0, 0,0,0,2,0,0},  // R4 code7 none
    '{0,0,0,0,0,0,1,0,31,3,0,0,4,0},  // R10 key31 -> bits 1:0
    '{2,0,0,0,0,0,1,0, 0,1,0,0,6,0}   // R10 key0 -> bits 63:62
  };

  task automatic drive(input logic [2:0] code, input logic nx, gd, usr, kp, ks, cken, fmen,
                       input logic [4:0] key, input logic [1:0] amrf, iamrf, kind);
    int pos;
    pos = 2 * (31 - int'(key));
    @(negedge clk);
    entry_word      = 64'h0000_FF00_0000_0000;
    entry_word[1:0] = code[1:0];
    entry_word[63]  = code[2];
    entry_word[2]   = nx;
    entry_word[3]   = gd;
    entry_word[12:8] = key;
    user_mode = usr; seg_key_user = kp; seg_key_sup = ks;
    key_en = cken; fetch_mask_en = fmen;
    load_store_mask = ~(64'd3 << pos) | (64'(amrf) << pos);
    fetch_mask      = ~(64'd3 << pos) | (64'(iamrf) << pos);
    acc_kind = kind;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_pp(input int key, input int code);
    logic [7:0] full, rx;
    full = (key == 0) ? 8'b0000_0111 : 8'b0000_0100;
    rx   = (key == 0) ? 8'b0100_1000 : 8'b0000_1010;
    if (full[code]) return 3'b111;
    if (rx[code])   return 3'b101;
    return 3'b000;
  endfunction

  function automatic logic [7:0] faults();
    return {2'b00, ifault_nxg, ifault_prot, ifault_key, dfault_prot, dfault_key, dfault_store};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    entry_word = '0; load_store_mask = '0; fetch_mask = '0;
    user_mode = 0; seg_key_user = 0; seg_key_sup = 0; key_en = 0; fetch_mask_en = 0; acc_kind = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // R7 idle state: all-zero inputs grant a load with every right.
    check("R7 idle perm", {5'b0, perm_rwx}, 8'd7);
    check("R7 idle grant", {7'b0, grant}, 8'd1);
    check("R9 idle faults", faults(), 8'd0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].code, TBL[i].nx, TBL[i].gd, TBL[i].usr, TBL[i].kp, TBL[i].ks, TBL[i].cken,
            TBL[i].fmen, TBL[i].key, TBL[i].amrf, TBL[i].iamrf, TBL[i].kind);
      check($sformatf("R7 table row %0d perm", i), {5'b0, perm_rwx}, {5'b0, TBL[i].eperm});
      check($sformatf("R7 table row %0d grant", i), {7'b0, grant}, {7'b0, TBL[i].egrant});
    end

    // R3 / R4: full code sweep under both keys, supervisor path.
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < 8; c++) begin
        drive(3'(c), 0, 0, 0, 0, 1'(k), 0, 0, 0, 0, 0, 2);
        check($sformatf("%s code %0d", (k == 0) ? "R3" : "R4", c), {5'b0, perm_rwx}, {5'b0, ref_pp(k, c)});
      end
    end

    // R2: user state picks the user key, not the supervisor key.
    drive(0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    check("R2 user key0", {5'b0, perm_rwx}, 8'd7);
    drive(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    check("R2 sup key1", {5'b0, perm_rwx}, 8'd0);

    // R8: fetch fault reasons {nxg,prot,key,dprot,dkey,dstore}.
    drive(4, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2);
    check("R8 nxg over prot", faults(), 8'b0010_0000);
    drive(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 2);
    check("R8 prot only", faults(), 8'b0001_0000);
    drive(0, 1, 0, 0, 0, 0, 1, 1, 5, 0, 1, 2);
    check("R8 nxg plus key", faults(), 8'b0010_1000);
    drive(0, 0, 0, 0, 0, 0, 1, 1, 5, 0, 1, 2);
    check("R8 key only", faults(), 8'b0000_1000);

    // R9: data faults.
    drive(3, 0, 0, 0, 0, 0, 1, 0, 9, 2, 0, 1);
    check("R9 store prot+key", faults(), 8'b0000_0111);
    drive(0, 0, 0, 0, 0, 0, 1, 0, 9, 1, 0, 0);
    check("R9 load key", faults(), 8'b0000_0010);
    drive(4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    check("R9 store prot", faults(), 8'b0000_0101);
    drive(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R9 grant clean", faults(), 8'd0);

    // R10: neighbouring key fields are all ones; key 16 field clear -> unaffected.
    drive(0, 0, 0, 0, 0, 0, 1, 1, 16, 0, 0, 1);
    check("R10 isolated key16", {5'b0, perm_rwx}, 8'd7);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule